// File: doc/BRIEF.md
# Reduced Test Access Port Controller

This block is a boundary-scan test access port for a synchronous memory. It runs the standard sixteen-state controller, steered by the mode-select input on each rising test clock. The controller has a three-bit instruction register and three data registers behind it. The first is a single-bit bypass stage. The second is a 32-bit identification word whose fields give the memory's depth and data width. The third is a pin-capture chain whose length is a parameter.

The instruction set is deliberately reduced. The sample instruction takes a snapshot of the pin values presented on `pins_in` during Capture-DR. Bits shifted into that chain are never driven anywhere, so there is no preload. Every code outside the implemented ones routes the bypass stage between the serial input and output, and no instruction can touch normal memory traffic. The serial output changes on the falling test clock. A companion enable is high only while the controller is in a shift state, so a pad can tri-state the line at all other times.

Top module: `scan_tap`

## Requirements
- R1: On each rising `tck` the controller moves through the standard sixteen-state graph according to `tms`. While `rst` is high at a rising edge, the controller enters Test-Logic-Reset.
- R2: Five consecutive rising edges with `tms` high put the controller in Test-Logic-Reset from any state.
- R3: While in Test-Logic-Reset, or when `rst` is high, the active instruction becomes the identification code 3'b001.
- R4: Capture-IR loads the instruction shift stage with 3'b001, whose two low bits are 01. Shift-IR moves bits LSB first, with `tdi` entering at the MSB. Update-IR makes the shifted value the active instruction.
- R5: Under the identification code, Capture-DR loads a 32-bit word, which shifts out LSB first. Its fields are: version [31:28] = 0, depth [27:23] = 5'b01000, width [22:18] = 5'b00011, bits [17:12] = 0, vendor [11:1] = 11'b00011100100, and bit 0 = 1.
- R6: Code 3'b111 selects a one-bit bypass stage. Capture loads 0 into it, and during Shift-DR `tdo` repeats `tdi` one clock later.
- R7: The unimplemented codes 3'b000, 3'b011, 3'b100, 3'b101 and 3'b110 behave exactly like bypass.
- R8: Code 3'b010 (sample) loads `pins_in` into the capture chain at Capture-DR. The chain shifts out LSB first.
- R9: Bits shifted into the capture chain have no effect on anything. The next sample capture reflects only `pins_in`.
- R10: `tdo` and `tdo_en` change only on falling `tck`. `tdo_en` is high exactly while the controller is in Shift-IR or Shift-DR.
- R11: In Pause-DR the shift contents hold. Returning through Exit2-DR to Shift-DR continues from the next bit.
- R12: If `rst` is high in the same cycle as Update-IR, the reset wins and the identification code stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| pins_in | input | BSR_LEN | Pin values captured by the sample instruction |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo`, high in shift states |

## Verification
Two events can land on the same rising edge: the Update-IR transfer of a freshly shifted instruction, and a synchronous reset that forces the identification code. The bench shifts in the bypass code, steps to Update-IR, and raises `rst` for exactly that edge. It then scans the data register. Receiving the full 32-bit identification word shows that reset won; receiving a single zero followed by the delayed `tdi` would show that the update won.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPT   = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    DSEL_BYPASS, DSEL_IDENT, DSEL_CHAIN
  } dr_sel_e;

endpackage

// File: rtl/scan_tap_fsm.sv
`timescale 1ns/1ps
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

endmodule

// File: rtl/scan_tap_ir.sv
`timescale 1ns/1ps
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_q,
  output dr_sel_e         dsel
);

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sh <= IR_CAPT;
    end else if (state == ST_CAP_IR) begin
      ir_sh <= IR_CAPT;
    end else if (state == ST_SH_IR) begin
      ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (rst || state == ST_RESET) ir_q <= OP_IDENT;
    else if (state == ST_UP_IR)   ir_q <= ir_sh;
  end

  always_comb begin
    case (ir_q)
      OP_IDENT:  dsel = DSEL_IDENT;
      OP_SAMPLE: dsel = DSEL_CHAIN;
      default:   dsel = DSEL_BYPASS;
    endcase
  end

endmodule

// File: rtl/scan_tap_dr.sv
`timescale 1ns/1ps
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN = 16,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
)(
  input  logic               tck,
  input  logic               rst,
  input  tap_state_e         state,
  input  dr_sel_e            dsel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_in,
  output logic               dr_lsb
);

  localparam int ID_LEN = 32;

  logic               byp_q;
  logic [ID_LEN-1:0]  id_sh;
  logic [BSR_LEN-1:0] chain_sh;

  logic cap, shf;
  assign cap = (state == ST_CAP_DR);
  assign shf = (state == ST_SH_DR);

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
    end else if (dsel == DSEL_BYPASS) begin
      if (cap)      byp_q <= 1'b0;
      else if (shf) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      id_sh <= ID_WORD;
    end else if (dsel == DSEL_IDENT) begin
      if (cap)      id_sh <= ID_WORD;
      else if (shf) id_sh <= {tdi, id_sh[ID_LEN-1:1]};
    end
  end

  generate
    if (BSR_LEN == 1) begin : g_chain_one
      always_ff @(posedge tck) begin
        if (rst) chain_sh <= '0;
        else if (dsel == DSEL_CHAIN) begin
          if (cap)      chain_sh <= pins_in;
          else if (shf) chain_sh <= tdi;
        end
      end
    end else begin : g_chain_multi
      always_ff @(posedge tck) begin
        if (rst) chain_sh <= '0;
        else if (dsel == DSEL_CHAIN) begin
          if (cap)      chain_sh <= pins_in;
          else if (shf) chain_sh <= {tdi, chain_sh[BSR_LEN-1:1]};
        end
      end
    end
  endgenerate

  always_comb begin
    case (dsel)
      DSEL_IDENT: dr_lsb = id_sh[0];
      DSEL_CHAIN: dr_lsb = chain_sh[0];
      default:    dr_lsb = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int           BSR_LEN   = 16,
  parameter logic [3:0]   ID_VER    = 4'h0,
  parameter logic [4:0]   ID_DEPTH  = 5'b01000,
  parameter logic [4:0]   ID_WIDTH  = 5'b00011,
  parameter logic [10:0]  ID_VENDOR = 11'b00011100100
)(
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_in,
  output logic               tdo,
  output logic               tdo_en
);

  localparam logic [31:0] ID_WORD = {ID_VER, ID_DEPTH, ID_WIDTH, 6'b0, ID_VENDOR, 1'b1};

  tap_state_e      state_q;
  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_q;
  dr_sel_e         dsel;
  logic            dr_lsb;

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state_q)
  );

  scan_tap_ir u_ir (
    .tck   (tck),
    .rst   (rst),
    .state (state_q),
    .tdi   (tdi),
    .ir_sh (ir_sh),
    .ir_q  (ir_q),
    .dsel  (dsel)
  );

  scan_tap_dr #(
    .BSR_LEN (BSR_LEN),
    .ID_WORD (ID_WORD)
  ) u_dr (
    .tck     (tck),
    .rst     (rst),
    .state   (state_q),
    .dsel    (dsel),
    .tdi     (tdi),
    .pins_in (pins_in),
    .dr_lsb  (dr_lsb)
  );

  // Output stage re-timed to the falling edge of the test clock
  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state_q == ST_SH_IR) || (state_q == ST_SH_DR);
      tdo    <= (state_q == ST_SH_IR) ? ir_sh[0] : dr_lsb;
    end
  end

endmodule

// File: rtl/scan_tap_chk.sv
`timescale 1ns/1ps
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input logic            tdo_en,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sh
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (rst || !tms)           ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt == 3'd5) |-> (state == ST_RESET)); // R2

  AST_RESET_LOADS_IDENT: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET) |=> (ir_q == OP_IDENT)); // R3

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> (ir_sh[1:0] == 2'b01)); // R4

  AST_IR_HOLDS_OFF_UPDATE: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UP_IR && state != ST_RESET) |=> $stable(ir_q)); // R4

  AST_TDO_EN_IN_SHIFT: assert property (@(posedge tck) disable iff (rst)
    tdo_en == (state == ST_SH_IR || state == ST_SH_DR)); // R10

endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck    (tck),
  .rst    (rst),
  .tms    (tms),
  .tdo_en (tdo_en),
  .state  (state_q),
  .ir_q   (ir_q),
  .ir_sh  (ir_sh)
);

// File: tb/test_scan_tap.sv
`timescale 1ns/1ps
module test_scan_tap;

  localparam int BSR_LEN = 16;
  localparam logic [31:0] ID_EXP = {4'h0, 5'b01000, 5'b00011, 6'b0, 11'b00011100100, 1'b1};

  logic               tck = 1'b0;
  logic               rst = 1'b1;
  logic               tms = 1'b1;
  logic               tdi = 1'b0;
  logic [BSR_LEN-1:0] pins_in = '0;
  logic               tdo;
  logic               tdo_en;

  int n_vec  = 0;
  int n_fail = 0;

  logic  q_bit[$];
  string q_tag[$];

  always #5 tck = ~tck;

  scan_tap #(.BSR_LEN(BSR_LEN)) i_scan_tap (
    .tck (tck), .rst (rst), .tms (tms), .tdi (tdi),
    .pins_in (pins_in), .tdo (tdo), .tdo_en (tdo_en)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: every falling-edge output slot with the enable high consumes one expected bit
  always @(negedge tck) begin
    #2;
    if (tdo_en === 1'b1) begin
      if (q_bit.size() == 0) begin
        check(1'b0, "R10 tdo_en high with nothing expected", 32'(tdo_en), 32'd0);
      end else begin
        logic  eb;
        string et;
        eb = q_bit.pop_front();
        et = q_tag.pop_front();
        check(tdo === eb, et, 32'(tdo), 32'(eb));
      end
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #3;
    tms = m;
    tdi = d;
  endtask

  task automatic push_bits(input int n, input logic [63:0] v, input string tag);
    for (int i = 0; i < n; i++) begin
      q_bit.push_back(v[i]);
      q_tag.push_back(tag);
    end
  endtask

  // From Run-Test/Idle back to Run-Test/Idle
  task automatic scan_ir(input logic [2:0] op, input string tag);
    push_bits(3, 64'b001, tag);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) step(i == 2, op[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] exp, input string tag);
    push_bits(n, exp, tag);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic idle_probe(input string tag);
    @(negedge tck);
    #2;
    check(tdo_en === 1'b0, tag, 32'(tdo_en), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    repeat (3) @(posedge tck);
    step(1, 0);
    step(1, 0);
    rst = 1'b0;
    idle_probe("R1 R10 tdo_en low after reset");
    step(0, 0);               // Test-Logic-Reset -> Run-Test/Idle
    idle_probe("R10 tdo_en low in idle");

    // R3 R5: identification word is active straight out of reset
    scan_dr(32, 64'hFFFF_FFFF, {32'b0, ID_EXP}, "R3 R5 identification word after reset");
    idle_probe("R10 tdo_en low after DR scan");

    // R6 R4: bypass delays tdi by one clock, capture bit 0
    scan_ir(3'b111, "R4 instruction capture pattern");
    pat = 8'b1011_0010;
    scan_dr(8, {56'b0, pat}, {56'b0, pat[6:0], 1'b0}, "R6 bypass one-clock delay");

    // R7: reserved codes behave as bypass
    scan_ir(3'b100, "R4 instruction capture pattern");
    pat = 8'b0110_1101;
    scan_dr(8, {56'b0, pat}, {56'b0, pat[6:0], 1'b0}, "R7 reserved code 100 as bypass");
    scan_ir(3'b000, "R4 instruction capture pattern");
    pat = 8'b1100_0111;
    scan_dr(8, {56'b0, pat}, {56'b0, pat[6:0], 1'b0}, "R7 reserved code 000 as bypass");

    // R8 R9: sample captures pins; shifted-in bits are not applied
    scan_ir(3'b010, "R4 instruction capture pattern");
    pins_in = 16'hA5C3;
    scan_dr(BSR_LEN, 64'hFFFF, 64'hA5C3, "R8 sample capture of pins");
    pins_in = 16'h0F0F;
    scan_dr(BSR_LEN, 64'h1234, 64'h0F0F, "R9 no preload, new capture shows only pins");

    // R2: five high TMS from Shift-DR under bypass
    scan_ir(3'b111, "R4 instruction capture pattern");
    push_bits(1, 64'b0, "R6 bypass capture bit before forced reset");
    step(1, 0); step(0, 0); step(0, 0);   // into Shift-DR
    step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    idle_probe("R2 tdo_en low in reset state");
    step(0, 0);
    scan_dr(32, 64'h0, {32'b0, ID_EXP}, "R2 R3 identification after five high TMS");

    // R11: pause mid-shift and resume
    push_bits(32, {32'b0, ID_EXP}, "R11 identification across pause");
    step(1, 0); step(0, 0); step(0, 0);   // into Shift-DR
    for (int i = 0; i < 10; i++) step(i == 9, 0);
    step(0, 0); step(0, 0); step(1, 0);   // Pause-DR, Pause-DR, Exit2-DR
    step(0, 0);                           // back to Shift-DR
    for (int i = 10; i < 32; i++) step(i == 31, 0);
    step(1, 0); step(0, 0);

    // R12: reset in the same cycle as Update-IR wins
    push_bits(3, 64'b001, "R4 instruction capture pattern");
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, 1); step(0, 1); step(1, 1);   // shift in 111, leave via Exit1-IR
    step(1, 0);                           // -> Update-IR
    @(negedge tck); #3; rst = 1'b1; tms = 1'b0;
    @(negedge tck); #3; rst = 1'b0; tms = 1'b0;   // Test-Logic-Reset -> idle
    step(0, 0);
    scan_dr(32, 64'h0, {32'b0, ID_EXP}, "R12 reset beats Update-IR");

    repeat (4) @(negedge tck);
    check(q_bit.size() == 0, "R10 all expected shift slots produced", 32'(q_bit.size()), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule